// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds two independent direction predictors and a chooser. The first predictor is a table of 2-bit saturating counters selected by the low bits of the branch address. The second is a correlating predictor: each of its rows holds four 2-bit counters, and a 2-bit global record of the most recent resolved branch outcomes picks one of them. A third table of 2-bit counters, also selected by the branch address, decides for each branch which of the two predictors supplies the final answer.

Front-end logic presents a program counter on the lookup side and receives the predicted direction in the same cycle. When a branch resolves, the back end presents its address and its real outcome on the update side. All three tables and the history train on the next clock edge. No tags are kept, so branches that share low address bits share counters. The global history moves only on resolved updates and is never repaired speculatively.

The lookup side is a combinational query: `pred_valid` follows `lk_valid` in the same cycle and there is no back-pressure. The update side is a one-way valid stream: every cycle with `upd_valid` high is taken as one resolved branch, and the block never stalls it.

Top module: `bp_tournament`

## Requirements
- R1: Every counter is 2 bits wide and predicts taken when its value is 2 or 3 (upper bit set) and not taken at 0 or 1; on training it moves one step toward the outcome and saturates at 0 and 3, so a strongly taken counter keeps predicting taken after one not-taken outcome.
- R2: The per-address table and the chooser are indexed by PC[LOCAL_IDX_W-1:0] and PC[SEL_IDX_W-1:0], the correlating table by {PC[CORR_IDX_W-1:0], history}; PC bits above these are ignored, so aliasing addresses share counters.
- R3: On an update only the one correlating counter selected by the history current at that update is trained; the other three counters of that row keep their values.
- R4: The final prediction is the correlating component's when the chooser counter for the PC is 2 or 3, and the per-address component's when it is 0 or 1.
- R5: The chooser counter is trained only when the two components predicted different directions at update time; it steps toward 3 when the correlating component was correct and toward 0 when the per-address component was correct, and otherwise keeps its value.
- R6: After every update the history shifts left by one bit and the resolved outcome enters bit 0; without an update it holds.
- R7: After reset every prediction counter is 01 (weakly not taken), every chooser counter is 01 (weakly selecting the per-address component) and the history is 00, so every lookup predicts not taken.
- R8: Lookup is combinational from `lk_pc`; an update changes the state from the next rising edge, and a lookup in the same cycle as an update sees the state before it.
- R9: `pred_valid` equals `lk_valid` in every cycle, and every update presented with `upd_valid` high is consumed in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_pc | input | PC_W | Address of the branch to predict |
| pred_valid | output | 1 | Prediction valid, follows lk_valid |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | Resolved branch present |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The assertions check on every cycle that a trained counter moves exactly one step or sits at a bound, that an untrained entry addressed by the update side keeps its value (which covers a chooser left alone when the components agree), and that the history shifts in the outcome on an update and holds otherwise. Only the bench scenarios can show the full behaviour: the hysteresis of a saturated counter, aliasing across high PC bits, a chooser that moves over to the correlating component on an alternating branch and then predicts it correctly, and a same-cycle lookup that still sees the state before the update.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'b01;
  localparam ctr_t CTR_MAX     = 2'b11;
  localparam ctr_t CTR_MIN     = 2'b00;

  // One saturating step toward the outcome
  function automatic ctr_t ctr_step(input ctr_t cur, input logic up);
    ctr_t nxt;
    if (up) nxt = (cur == CTR_MAX) ? cur : cur + 2'd1;
    else    nxt = (cur == CTR_MIN) ? cur : cur - 2'd1;
    return nxt;
  endfunction
endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import bp_pkg::*;
#(
  parameter int   IDX_W   = 10,
  parameter ctr_t RST_VAL = CTR_WEAK_NT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] a_idx,
  output ctr_t             a_ctr,
  input  logic [IDX_W-1:0] b_idx,
  output ctr_t             b_ctr,
  input  logic             wr_en,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem [DEPTH];

  assign a_ctr = mem[a_idx];
  assign b_ctr = mem[b_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= RST_VAL;
    end else if (wr_en) begin
      mem[b_idx] <= ctr_step(mem[b_idx], wr_up);
    end
  end

  // R1: a trained counter rises by one or stays at the top
  p_step_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_up) |=> ((mem[$past(b_idx)] == $past(mem[b_idx]) + 2'd1) ||
                          ($past(mem[b_idx]) == CTR_MAX && mem[$past(b_idx)] == CTR_MAX)));

  // R1: a trained counter falls by one or stays at the bottom
  p_step_dn_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_up) |=> ((mem[$past(b_idx)] == $past(mem[b_idx]) - 2'd1) ||
                           ($past(mem[b_idx]) == CTR_MIN && mem[$past(b_idx)] == CTR_MIN)));

  // R5: an entry addressed but not trained keeps its value
  p_no_write_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (mem[$past(b_idx)] == $past(mem[b_idx])));
endmodule

// File: rtl/bp_ghist.sv
module bp_ghist #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (!rst_n)        hist <= '0;
    else if (shift_en) hist <= {hist[HIST_W-2:0], bit_in};
  end

  // R6: the outcome enters bit 0 and older bits move up
  p_hist_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (hist[0] == $past(bit_in)) && (hist[HIST_W-1:1] == $past(hist[HIST_W-2:0])));

  // R6: history holds when no update arrives
  p_hist_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist));
endmodule

// File: rtl/bp_tournament.sv
module bp_tournament
  import bp_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int LOCAL_IDX_W = 10,
  parameter int CORR_IDX_W  = 8,
  parameter int SEL_IDX_W   = 10,
  parameter int HIST_W      = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  output logic            pred_valid,
  output logic            pred_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  localparam int CORR_ROW_W = CORR_IDX_W + HIST_W;

  logic [HIST_W-1:0] ghist;
  ctr_t loc_lk, loc_up, cor_lk, cor_up, sel_lk, sel_up;
  logic comp_disagree, corr_right;

  // Per-address component
  bp_ctr_table #(.IDX_W(LOCAL_IDX_W), .RST_VAL(CTR_WEAK_NT)) u_local (
    .clk(clk), .rst_n(rst_n),
    .a_idx(lk_pc[LOCAL_IDX_W-1:0]),  .a_ctr(loc_lk),
    .b_idx(upd_pc[LOCAL_IDX_W-1:0]), .b_ctr(loc_up),
    .wr_en(upd_valid), .wr_up(upd_taken)
  );

  // Correlating component: the history picks one counter of the row
  bp_ctr_table #(.IDX_W(CORR_ROW_W), .RST_VAL(CTR_WEAK_NT)) u_corr (
    .clk(clk), .rst_n(rst_n),
    .a_idx({lk_pc[CORR_IDX_W-1:0], ghist}),  .a_ctr(cor_lk),
    .b_idx({upd_pc[CORR_IDX_W-1:0], ghist}), .b_ctr(cor_up),
    .wr_en(upd_valid), .wr_up(upd_taken)
  );

  // Chooser trains only when the components disagree
  assign comp_disagree = loc_up[1] ^ cor_up[1];
  assign corr_right    = (cor_up[1] == upd_taken);

  bp_ctr_table #(.IDX_W(SEL_IDX_W), .RST_VAL(CTR_WEAK_NT)) u_sel (
    .clk(clk), .rst_n(rst_n),
    .a_idx(lk_pc[SEL_IDX_W-1:0]),  .a_ctr(sel_lk),
    .b_idx(upd_pc[SEL_IDX_W-1:0]), .b_ctr(sel_up),
    .wr_en(upd_valid && comp_disagree), .wr_up(corr_right)
  );

  bp_ghist #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .shift_en(upd_valid), .bit_in(upd_taken), .hist(ghist)
  );

  assign pred_valid = lk_valid;
  assign pred_taken = sel_lk[1] ? cor_lk[1] : loc_lk[1];

  // R4: with both components agreeing, the answer is theirs whatever the chooser
  always_comb begin
    if (rst_n && (loc_lk[1] == cor_lk[1]))
      a_agree_r4: assert (pred_taken == loc_lk[1]);
  end
endmodule

// File: tb/bp_tournament_test.sv
module bp_tournament_test;
  localparam int LW = 10, CW = 8, SW = 10;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, upd_valid = 0, upd_taken = 0;
  logic [31:0] lk_pc = 0, upd_pc = 0;
  logic pred_valid, pred_taken;
  int n_chk = 0, n_fail = 0;

  // independent reference state
  int m_loc [1 << LW];
  int m_cor [1 << (CW + 2)];
  int m_sel [1 << SW];
  int m_hist;

  always #2.5 clk = ~clk;

  bp_tournament uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  function automatic int sat(int c, bit up);
    return up ? ((c == 3) ? 3 : c + 1) : ((c == 0) ? 0 : c - 1);
  endfunction

  function automatic bit m_pred(logic [31:0] pc);
    int li = pc % (1 << LW), ci = (pc % (1 << CW)) * 4 + m_hist, si = pc % (1 << SW);
    return (m_sel[si] >= 2) ? (m_cor[ci] >= 2) : (m_loc[li] >= 2);
  endfunction

  task automatic chk(string req, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b", req, got, exp);
    end
  endtask

  task automatic model_reset();
    foreach (m_loc[i]) m_loc[i] = 1;
    foreach (m_cor[i]) m_cor[i] = 1;
    foreach (m_sel[i]) m_sel[i] = 1;
    m_hist = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; upd_valid = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    model_reset();
  endtask

  task automatic update(logic [31:0] pc, bit t);
    int li = pc % (1 << LW), ci = (pc % (1 << CW)) * 4 + m_hist, si = pc % (1 << SW);
    bit lp = m_loc[li] >= 2, cp = m_cor[ci] >= 2;
    @(negedge clk); upd_valid = 1; upd_pc = pc; upd_taken = t;
    @(negedge clk); upd_valid = 0;
    if (lp != cp) m_sel[si] = sat(m_sel[si], cp == t);
    m_loc[li] = sat(m_loc[li], t);
    m_cor[ci] = sat(m_cor[ci], t);
    m_hist = ((m_hist << 1) | int'(t)) & 3;
  endtask

  task automatic look(string req, logic [31:0] pc, logic exp);
    lk_pc = pc; lk_valid = 1; #1;
    chk(req, pred_taken, exp);
    chk({req, " model"}, pred_taken, m_pred(pc));
  endtask

  task automatic t_reset();   // R7, R9
    do_reset();
    lk_valid = 0; #1; chk("R9 idle", pred_valid, 0);
    lk_valid = 1; #1; chk("R9 valid", pred_valid, 1);
    look("R7 pc0", 32'h0, 0);
    look("R7 pc3ff", 32'h3ff, 0);
    look("R7 pcbig", 32'hdead_beef, 0);
  endtask

  task automatic t_hysteresis();   // R1
    do_reset();
    update(32'h40, 1);        // local 10, corr(h0) 10
    look("R1 one taken", 32'h40, 1);
    repeat (3) update(32'h40, 1);
    update(32'h40, 0);        // local 11 -> 10
    look("R1 hysteresis", 32'h40, 1);
    update(32'h40, 0);        // local 01
    look("R1 flip", 32'h40, 0);
  endtask

  task automatic t_alias();   // R2
    do_reset();
    repeat (3) update(32'h77, 1);
    look("R2 alias high bits", 32'h77 + (1 << LW), 1);
    look("R2 other index", 32'h78, 0);
  endtask

  task automatic t_alternate();   // R3, R4, R5, R6
    bit t = 1;
    do_reset();
    for (int i = 0; i < 24; i++) begin
      update(32'h120, t);
      t = !t;
    end
    look("R5 chooser moved", 32'h120, t);
    chk("R5 chooser state", m_sel[32'h120 % (1 << SW)] >= 2, 1);
    for (int i = 0; i < 6; i++) begin
      look("R4 alternating pred", 32'h120, t);
      update(32'h120, t);
      t = !t;
    end
    // R6: history now ends ...,!t ; correlating row reflects it
    look("R6 history select", 32'h120, t);
  endtask

  task automatic t_selected_only();   // R3
    do_reset();
    update(32'h10, 1);        // hist 00 -> 01, trains corr[10,h0]
    update(32'h10, 1);        // trains corr[10,h1]
    update(32'h55, 0);        // hist 11 -> 10
    update(32'h55, 0);        // hist -> 00
    // local for 0x10 is 11; corr h0 =10 h1=10 h2=01 h3=01
    chk("R3 untouched h2", m_cor[32'h10 * 4 + 2], 1);
    look("R3 pred", 32'h10, 1);
  endtask

  task automatic t_same_cycle();   // R8
    do_reset();
    @(negedge clk);
    upd_valid = 1; upd_pc = 32'h200; upd_taken = 1;
    lk_pc = 32'h200; lk_valid = 1; #1;
    chk("R8 old state during update", pred_taken, 0);
    @(negedge clk); upd_valid = 0;
    m_loc[32'h200 % (1 << LW)] = 2; m_cor[(32'h200 % (1 << CW)) * 4] = 2; m_hist = 1;
    look("R8 new state after edge", 32'h200, 1);
  endtask

  initial begin
    t_reset();
    t_hysteresis();
    t_alias();
    t_alternate();
    t_selected_only();
    t_same_cycle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule